// File: doc/BRIEF.md
# Timer DMA Burst Register Access

This block sits inside a timer and lets one DMA channel update a run of timer registers each time an internal timer event fires. Software enables one or more event sources for DMA service and programs a configuration word holding a start index and a beat count. When an enabled event occurs, the block raises a DMA request and holds it until the whole burst has been served.

The DMA engine moves data from memory to the peripheral and always accesses the same bus address, the burst window port. That port stores nothing itself. Each access to it is steered onto one of the block's target registers. The target is chosen by the start index plus a running offset, and the offset steps by one on every access. After the programmed number of beats the offset returns to zero and the request drops. The target registers can also be reached directly on the register bus, and their contents are exported to the rest of the timer.

Register map (word addresses): 0 holds the burst configuration, with the start index in bits 4:0 and the beat count minus one in bits 12:8. Address 1 holds the per-event DMA enables in bits 3:0. Address 2 is the burst window port. Addresses 8 to 8+NREG-1 are the target registers 0 to NREG-1. Any other address reads as zero.

Top module: `tmr_dma_burst`

## Requirements
- R1: After reset the configuration word, the event enables, every target register, the running offset and `dma_req` are all zero.
- R2: `dma_req` rises on the clock edge that samples an event input bit i high while enable bit i (address 1, bit i) is set; an event whose enable bit is clear raises no request.
- R3: A write to the window port (address 2) stores the data in target register start+offset, and every window access (read or write) advances the offset by one.
- R4: A read of the window port returns target register start+offset in the same cycle.
- R5: The count field (address 0, bits 12:8) holds beats minus one: after count+1 window accesses, the offset is back at 0 and `dma_req` is low. A count of 0 gives a one-beat burst.
- R6: Any write to the configuration word resets the offset to 0 and drops `dma_req`.
- R7: Events that arrive while `dma_req` is high are ignored: the request stays high and the offset is not disturbed.
- R8: A window access whose index start+offset is NREG or above reads as zero and leaves every target unchanged, but still advances the offset.
- R9: Target register i reads and writes directly at address 8+i, and this does not move the offset.
- R10: The configuration word reads back with bits 4:0 and 12:8 as written and all other bits zero; the enable word reads back with only bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register bus write strobe, one cycle per access |
| bus_rd | input | 1 | Register bus read strobe, one cycle per access |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the cycle of the access |
| evt | input | NEVT | Internal timer event pulses |
| dma_req | output | 1 | DMA request, held until the burst completes |
| tgt_q | output | NREG*DW | Contents of all target registers, register i at bits i*DW upward |

## Verification
The hardest situation to reach is a burst whose window runs past the last implemented target. Here the write and read beats must land partly inside and partly outside the bank, and the wrap of the offset must still clear the request. Random testing seldom reaches this unless start values near NREG are drawn together with a live request. The random phase therefore draws start indices up to NREG+1 and counts up to 7, and it fires events often enough that window accesses mostly occur inside live bursts. Directed cases add a burst that straddles the top of the bank, a one-beat burst, an event during a burst and a configuration write in the middle of a burst.

// File: rtl/tdb_pkg.sv
// Package: shared field layout and address map of the timer DMA burst block.
// Assumes word addressing on the register bus and a 16-bit or wider data bus.
package tdb_pkg;
    localparam int unsigned SAW       = 5;   // start-index field width
    localparam int unsigned CW        = 5;   // count field width
    localparam int unsigned CNT_LSB   = 8;   // bit position of the count field
    localparam int unsigned ADDR_CFG  = 0;
    localparam int unsigned ADDR_EN   = 1;
    localparam int unsigned ADDR_WIN  = 2;
    localparam int unsigned TGT_BASE  = 8;
    localparam int unsigned IW        = ((SAW > CW) ? SAW : CW) + 1; // index width
endpackage

// File: rtl/tdb_cfg_regs.sv
// Module: holds the burst configuration (start index, beat count) and the
// per-event DMA enables, and forms their read-back words.
// Assumes NEVT <= DW and CNT_LSB + CW <= DW.
module tdb_cfg_regs
    import tdb_pkg::*;
#(
    parameter int unsigned DW   = 16,
    parameter int unsigned NEVT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            en_we,
    input  logic [DW-1:0]   wdata,
    output logic [SAW-1:0]  start,
    output logic [CW-1:0]   count,
    output logic [NEVT-1:0] evt_en,
    output logic [DW-1:0]   cfg_word,
    output logic [DW-1:0]   en_word
);
    // Capture configuration fields on a write to the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start <= '0;
            count <= '0;
        end else if (cfg_we) begin
            start <= wdata[SAW-1:0];
            count <= wdata[CNT_LSB +: CW];
        end
    end

    // Capture event enables on a write to the enable word.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_en <= '0;
        else if (en_we) evt_en <= wdata[NEVT-1:0];
    end

    // Build read-back words with unused bits at zero.
    always_comb begin
        cfg_word                  = '0;
        cfg_word[SAW-1:0]         = start;
        cfg_word[CNT_LSB +: CW]   = count;
        en_word                   = '0;
        en_word[NEVT-1:0]         = evt_en;
    end
endmodule

// File: rtl/tdb_burst_seq.sv
// Module: burst sequencer. Starts a burst on an enabled event, steps the
// running offset on every window access and ends the burst after count+1
// beats. A configuration write aborts the burst.
// Assumes at most one window access per cycle.
module tdb_burst_seq
    import tdb_pkg::*;
#(
    parameter int unsigned NEVT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            win_acc,
    input  logic [NEVT-1:0] evt,
    input  logic [NEVT-1:0] evt_en,
    input  logic [SAW-1:0]  start,
    input  logic [CW-1:0]   count,
    output logic [CW-1:0]   offset,
    output logic [IW-1:0]   idx,
    output logic            dma_req
);
    logic last_beat;
    logic trig;

    // Decode the final beat and a qualified trigger.
    always_comb begin
        last_beat = (offset == count);
        trig      = |(evt & evt_en);
        idx       = IW'(start) + IW'(offset);
    end

    // Offset counter: steps per window access, wraps after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n)                  offset <= '0;
        else if (cfg_we)             offset <= '0;
        else if (win_acc)            offset <= last_beat ? '0 : offset + 1'b1;
    end

    // Request flag: set by an enabled event when idle, cleared at burst end.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dma_req <= 1'b0;
        else if (cfg_we)                     dma_req <= 1'b0;
        else if (dma_req) begin
            if (win_acc && last_beat)        dma_req <= 1'b0;
        end else if (trig)                   dma_req <= 1'b1;
    end
endmodule

// File: rtl/tdb_target_bank.sv
// Module: bank of NREG target registers, written either directly or through
// the burst window, with a direct read port and a window read port.
// Window indices at or above NREG read zero and write nothing.
module tdb_target_bank
    import tdb_pkg::*;
#(
    parameter int unsigned NREG = 8,
    parameter int unsigned DW   = 16,
    localparam int unsigned XW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir_we,
    input  logic [XW-1:0]      dir_idx,
    input  logic               win_we,
    input  logic [IW-1:0]      win_idx,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      dir_rdata,
    output logic [DW-1:0]      win_rdata,
    output logic [NREG*DW-1:0] tgt_q
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit;
        // Select this register for a direct or a window write.
        always_comb hit = (dir_we && dir_idx == XW'(g)) ||
                          (win_we && win_idx == IW'(g));
        // Target register storage.
        always_ff @(posedge clk) begin
            if (!rst_n)   regs[g] <= '0;
            else if (hit) regs[g] <= wdata;
        end
        assign tgt_q[g*DW +: DW] = regs[g];
    end

    // Read multiplexers for both ports; out-of-range window reads give zero.
    always_comb begin
        dir_rdata = '0;
        win_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (dir_idx == XW'(i)) dir_rdata = regs[i];
            if (win_idx == IW'(i)) win_rdata = regs[i];
        end
    end
endmodule

// File: rtl/tmr_dma_burst.sv
// Module: top of the timer DMA burst access block. Decodes the register bus,
// routes window accesses through the burst sequencer onto the target bank and
// drives the DMA request.
// Assumes bus_wr and bus_rd are never high together; NREG <= 2**AW - TGT_BASE.
module tmr_dma_burst
    import tdb_pkg::*;
#(
    parameter int unsigned NREG = 8,
    parameter int unsigned DW   = 16,
    parameter int unsigned AW   = 6,
    parameter int unsigned NEVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NEVT-1:0]    evt,
    output logic               dma_req,
    output logic [NREG*DW-1:0] tgt_q
);
    localparam int unsigned XW = (NREG > 1) ? $clog2(NREG) : 1;

    logic            sel_cfg, sel_en, sel_win, sel_tgt;
    logic            cfg_we, en_we, win_acc, win_rd;
    logic [AW-1:0]   tgt_off;
    logic [XW-1:0]   dir_idx;
    logic [SAW-1:0]  start;
    logic [CW-1:0]   count;
    logic [NEVT-1:0] evt_en;
    logic [DW-1:0]   cfg_word, en_word, dir_rdata, win_rdata;
    logic [CW-1:0]   offset;
    logic [IW-1:0]   idx;

    // Address decode and access strobes.
    always_comb begin
        sel_cfg = (bus_addr == AW'(ADDR_CFG));
        sel_en  = (bus_addr == AW'(ADDR_EN));
        sel_win = (bus_addr == AW'(ADDR_WIN));
        tgt_off = bus_addr - AW'(TGT_BASE);
        sel_tgt = (bus_addr >= AW'(TGT_BASE)) && (tgt_off < AW'(NREG));
        dir_idx = XW'(tgt_off);
        cfg_we  = bus_wr && sel_cfg;
        en_we   = bus_wr && sel_en;
        win_acc = (bus_wr || bus_rd) && sel_win;
        win_rd  = bus_rd && sel_win;
    end

    tdb_cfg_regs #(.DW(DW), .NEVT(NEVT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .en_we(en_we),
        .wdata(bus_wdata), .start(start), .count(count), .evt_en(evt_en),
        .cfg_word(cfg_word), .en_word(en_word)
    );

    tdb_burst_seq #(.NEVT(NEVT)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .win_acc(win_acc),
        .evt(evt), .evt_en(evt_en), .start(start), .count(count),
        .offset(offset), .idx(idx), .dma_req(dma_req)
    );

    tdb_target_bank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .dir_we(bus_wr && sel_tgt), .dir_idx(dir_idx),
        .win_we(bus_wr && sel_win), .win_idx(idx), .wdata(bus_wdata),
        .dir_rdata(dir_rdata), .win_rdata(win_rdata), .tgt_q(tgt_q)
    );

    // Read data multiplexer; unmapped addresses read zero.
    always_comb begin
        if (sel_cfg)      bus_rdata = cfg_word;
        else if (sel_en)  bus_rdata = en_word;
        else if (sel_win) bus_rdata = win_rdata;
        else if (sel_tgt) bus_rdata = dir_rdata;
        else              bus_rdata = '0;
    end
endmodule

// File: rtl/tdb_checker.sv
// Module: protocol checker for tmr_dma_burst, attached by bind below.
// Assumes the same field widths as the block (taken from tdb_pkg).
module tdb_checker
    import tdb_pkg::*;
#(
    parameter int unsigned NREG = 8,
    parameter int unsigned DW   = 16,
    parameter int unsigned NEVT = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic            win_acc,
    input logic            win_rd,
    input logic [NEVT-1:0] evt,
    input logic [NEVT-1:0] evt_en,
    input logic            dma_req,
    input logic [CW-1:0]   offset,
    input logic [CW-1:0]   count,
    input logic [IW-1:0]   idx,
    input logic [DW-1:0]   bus_rdata
);
    // R2: a new request needs an enabled event on the previous edge.
    p_req_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(|(evt & evt_en)));

    // R3: a non-final window access steps the offset by one.
    p_offset_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !cfg_we && offset != count) |=> offset == $past(offset) + 1'b1);

    // R5: the final beat of a live burst drops the request and wraps.
    p_burst_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && win_acc && !cfg_we && offset == count) |=> (!dma_req && offset == '0));

    // R6: a configuration write clears offset and request.
    p_cfg_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!dma_req && offset == '0));

    // R7: a live request is kept while no last beat or config write occurs.
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !cfg_we && !(win_acc && offset == count)) |=> dma_req);

    // R8: out-of-range window reads return zero.
    p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && idx >= IW'(NREG)) |-> bus_rdata == '0);
endmodule

bind tmr_dma_burst tdb_checker #(.NREG(NREG), .DW(DW), .NEVT(NEVT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .win_acc(win_acc),
    .win_rd(win_rd), .evt(evt), .evt_en(evt_en), .dma_req(dma_req),
    .offset(offset), .count(count), .idx(idx), .bus_rdata(bus_rdata)
);

// File: tb/tmr_dma_burst_tb.sv
module tmr_dma_burst_tb;
    localparam int NREG = 8;
    localparam int DW   = 16;
    localparam int AW   = 6;
    localparam int NEVT = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0]      bus_addr = '0;
    logic [DW-1:0]      bus_wdata = '0;
    logic [DW-1:0]      bus_rdata;
    logic [NEVT-1:0]    evt = '0;
    logic               dma_req;
    logic [NREG*DW-1:0] tgt_q;

    int n_chk = 0, n_fail = 0, cyc = 0;

    // Bench model state
    logic [DW-1:0]   m_tgt [NREG];
    logic [4:0]      m_start, m_cnt, m_off;
    logic [NEVT-1:0] m_en;
    logic            m_busy;

    tmr_dma_burst #(.NREG(NREG), .DW(DW), .AW(AW), .NEVT(NEVT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt(evt), .dma_req(dma_req), .tgt_q(tgt_q)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        logic [5:0] ix;
        ix = {1'b0, m_start} + {1'b0, m_off};
        if (a == 0) return {3'b0, m_cnt, 3'b0, m_start};
        if (a == 1) return {{(DW-NEVT){1'b0}}, m_en};
        if (a == 2) return (ix < NREG) ? m_tgt[ix[2:0]] : '0;
        if (a >= 8 && a < 8 + NREG) return m_tgt[a - 8];
        return '0;
    endfunction

    // Apply one bus access or event cycle to the model.
    task automatic m_apply(input bit wr, input bit rd, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic [NEVT-1:0] e);
        logic [5:0] ix;
        ix = {1'b0, m_start} + {1'b0, m_off};
        if (wr && a == 0) begin
            m_start = d[4:0]; m_cnt = d[12:8]; m_off = 0; m_busy = 0;
        end else begin
            if (wr && a == 1) m_en = d[NEVT-1:0];
            if (wr && a >= 8 && a < 8 + NREG) m_tgt[a - 8] = d;
            if ((wr || rd) && a == 2) begin
                if (wr && ix < NREG) m_tgt[ix[2:0]] = d;
                if (m_off == m_cnt) begin
                    m_off = 0;
                    if (m_busy) m_busy = 0;
                end else m_off = m_off + 1;
            end else if (!m_busy && |(e & m_en)) m_busy = 1;
        end
    endtask

    // One cycle: drive, sample read data, clock, then compare request.
    task automatic op(input bit wr, input bit rd, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [NEVT-1:0] e, input string tag);
        logic [DW-1:0] got, want;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evt = e;
        #2;
        got = bus_rdata;
        if (rd) begin
            want = exp_read(a);
            check(got == want, tag, 32'(got), 32'(want));
        end
        @(posedge clk);
        m_apply(wr, rd, a, d, e);
        #2;
        bus_wr = 0; bus_rd = 0; evt = '0;
        check(dma_req == m_busy, {tag, " req"}, 32'(dma_req), 32'(m_busy));
    endtask

    task automatic wr_(input logic [AW-1:0] a, input logic [DW-1:0] d, input string t);
        op(1, 0, a, d, '0, t);
    endtask
    task automatic rd_(input logic [AW-1:0] a, input string t);
        op(0, 1, a, '0, '0, t);
    endtask
    task automatic ev_(input logic [NEVT-1:0] e, input string t);
        op(0, 0, 0, '0, e, t);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) m_tgt[i] = '0;
        m_start = 0; m_cnt = 0; m_off = 0; m_en = 0; m_busy = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        check(dma_req == 0, "R1 req", 32'(dma_req), 0);
        check(tgt_q == '0, "R1 tgt_q", tgt_q[31:0], 0);
        rd_(0, "R1 cfg");
        rd_(1, "R1 en");
        for (int i = 0; i < NREG; i++) rd_(AW'(8 + i), "R1 tgt");

        // R9: direct target access, offset untouched
        for (int i = 0; i < NREG; i++) wr_(AW'(8 + i), DW'(16'h1100 + i), "R9 wr");
        for (int i = 0; i < NREG; i++) rd_(AW'(8 + i), "R9 rd");
        check(tgt_q[3*DW +: DW] == 16'h1103, "R9 tgt_q", 32'(tgt_q[3*DW +: DW]), 32'h1103);

        // R2: disabled event ignored, wrong bit ignored, enabled bit triggers
        wr_(0, 16'h0201, "R10 cfg");      // start 1, count 2
        ev_(4'b0001, "R2 disabled");
        wr_(1, 16'h0001, "R2 en");
        ev_(4'b0010, "R2 other bit");
        ev_(4'b0001, "R2 trigger");

        // R3/R7/R5: three-beat burst with an event in the middle
        wr_(2, 16'hA001, "R3 beat0");
        ev_(4'b0001, "R7 evt in burst");
        wr_(2, 16'hA002, "R7 beat1");
        wr_(2, 16'hA003, "R5 beat2 last");
        rd_(9, "R3 t1"); rd_(10, "R3 t2"); rd_(11, "R3 t3");

        // R5/R4: one-beat burst with a read
        wr_(0, 16'h0004, "R5 cfg count0");
        ev_(4'b0001, "R5 trig");
        rd_(2, "R4 window read");

        // R8: burst straddling the top of the bank
        wr_(0, 16'h0306, "R8 cfg");
        ev_(4'b0001, "R8 trig");
        for (int i = 0; i < 4; i++) wr_(2, DW'(16'hB000 + i), "R8 beat");
        for (int i = 0; i < NREG; i++) rd_(AW'(8 + i), "R8 bank");
        wr_(0, 16'h0107, "R8 cfg2");
        rd_(2, "R8 rd in"); rd_(2, "R8 rd oob");

        // R6: configuration write mid-burst
        wr_(0, 16'h0500, "R6 cfg");
        ev_(4'b0001, "R6 trig");
        rd_(2, "R6 b0"); rd_(2, "R6 b1");
        wr_(0, 16'h0500, "R6 abort");
        rd_(2, "R6 offset reset");

        // R10: read-back masks
        wr_(0, 16'hFFFF, "R10 cfg all");
        rd_(0, "R10 cfg mask");
        wr_(1, 16'hFFFF, "R10 en all");
        rd_(1, "R10 en mask");

        // Random phase
        for (int k = 0; k < 1500; k++) begin
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: wr_(0, DW'({$urandom_range(0, 7), 8'h00} | $urandom_range(0, NREG + 1)), "R6 rnd cfg");
                1: wr_(1, DW'($urandom), "R2 rnd en");
                2, 3: ev_(NEVT'($urandom), "R7 rnd evt");
                4, 5: wr_(2, DW'($urandom), "R3 rnd win wr");
                6, 7: rd_(2, "R4 rnd win rd");
                8: wr_(AW'(8 + $urandom_range(0, NREG - 1)), DW'($urandom), "R9 rnd dir wr");
                default: rd_(AW'($urandom_range(0, 2 ** AW - 1)), "R9 rnd rd");
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule